// File: doc/BRIEF.md
# Cascadable Four-Bit ALU Slice

This block is a purely combinational arithmetic/logic unit built from four-bit slices. Each slice takes two four-bit operands, a carry input and a three-bit function code. It returns a four-bit result, a carry output and a signed-overflow flag. The function code selects one of eight operations:

- three arithmetic operations: addition, and subtraction in either order;
- three bitwise operations;
- two operations that force the result to a constant.

Subtraction is built as the addition of the inverted subtrahend plus the carry input. A true difference therefore needs the carry input of the lowest slice held at 1.

The top module chains a parameterised number of slices. Each slice's carry output feeds the next slice's carry input, so the word can be made wider. The overflow flag of the whole word comes from the most significant slice only. With the default of four slices the top forms a 16-bit ALU.

Top module: `alu_chain`

## Requirements
- R1: Function code 000 (clear) drives every result bit to 0 and drives both carry_out and overflow to 1, whatever the carry input.
- R2: Function code 111 (preset) drives every result bit to 1 and drives carry_out and overflow to 0.
- R3: Function code 011 (add) gives {carry_out, result} equal to a_in + b_in + carry_in over the full word width.
- R4: Function code 010 gives {carry_out, result} equal to a_in + ~b_in + carry_in. With carry_in = 1 the result is a_in − b_in, and carry_out = 1 means no borrow occurred.
- R5: Function code 001 gives {carry_out, result} equal to b_in + ~a_in + carry_in. With carry_in = 1 the result is b_in − a_in.
- R6: Function codes 100, 101 and 110 give the bitwise XOR, OR and AND of the operands respectively, with carry_out and overflow driven to 0.
- R7: In the three arithmetic codes, overflow is the XOR of the carry into the word's top bit and carry_out. It is 1 exactly when the two's-complement result is out of range for the word width.
- R8: Carries ripple from slice to slice, so a carry produced in the lowest slice propagates through all higher slices within the same evaluation.
- R9: The slice count is a parameter (default 4, giving a 16-bit word). The same function table applies at every count, including a single slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 4*NSLICES | First operand |
| b_in | input | 4*NSLICES | Second operand |
| carry_in | input | 1 | Carry into the lowest slice |
| func_sel | input | 3 | Function code |
| result | output | 4*NSLICES | Function result |
| carry_out | output | 1 | Carry out of the highest slice |
| overflow | output | 1 | Two's-complement overflow of the top slice |

## Verification
The block holds no state, so any fault appears at the ports in the same evaluation as the stimulus that exposes it. A broken inversion or carry in one bit shows up as a wrong sum or difference. It only shows when the operands make that bit's carry matter, which is why the single slice is swept over every operand, carry and code. A broken link between slices appears only in the chained word: a carry from a low nibble fails to reach the high nibbles, or a wrong slice feeds the overflow. Random and directed 16-bit vectors target those paths.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

  localparam int SLICE_W = 4;

  typedef enum logic [2:0] {
    FN_CLEAR  = 3'b000,
    FN_BSUBA  = 3'b001,
    FN_ASUBB  = 3'b010,
    FN_ADD    = 3'b011,
    FN_XOR    = 3'b100,
    FN_OR     = 3'b101,
    FN_AND    = 3'b110,
    FN_PRESET = 3'b111
  } fn_e;

  typedef enum logic [1:0] {
    LG_XOR = 2'd0,
    LG_OR  = 2'd1,
    LG_AND = 2'd2
  } lg_e;

  typedef struct packed {
    logic arith;
    logic inv_a;
    logic inv_b;
    logic force_lo;
    logic force_hi;
    lg_e  lop;
  } slice_ctl_t;

  function automatic logic fa_sum(input logic x, input logic y, input logic c);
    return x ^ y ^ c;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic c);
    return (x & y) | (x & c) | (y & c);
  endfunction

endpackage

// File: rtl/slice_decode.sv
module slice_decode
  import alu_slice_pkg::*;
(
  input  logic [2:0]  fn_code,
  output slice_ctl_t  ctl
);
  always_comb begin
    ctl = '{arith: 1'b0, inv_a: 1'b0, inv_b: 1'b0, force_lo: 1'b0,
            force_hi: 1'b0, lop: LG_XOR};
    unique case (fn_e'(fn_code))
      FN_CLEAR:  ctl.force_lo = 1'b1;
      FN_BSUBA:  begin ctl.arith = 1'b1; ctl.inv_a = 1'b1; end
      FN_ASUBB:  begin ctl.arith = 1'b1; ctl.inv_b = 1'b1; end
      FN_ADD:    ctl.arith = 1'b1;
      FN_XOR:    ctl.lop = LG_XOR;
      FN_OR:     ctl.lop = LG_OR;
      FN_AND:    ctl.lop = LG_AND;
      FN_PRESET: ctl.force_hi = 1'b1;
      default:   ctl.force_lo = 1'b1;
    endcase
  end
endmodule

// File: rtl/slice_adder.sv
module slice_adder
  import alu_slice_pkg::*;
#(
  parameter int W = SLICE_W
) (
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  input  logic         inv_x,
  input  logic         inv_y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic [W:0]   carries
);
  logic [W-1:0] xo, yo;

  assign xo = inv_x ? ~x_in : x_in;
  assign yo = inv_y ? ~y_in : y_in;
  assign carries[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i]         = fa_sum(xo[i], yo[i], carries[i]);
    assign carries[i + 1] = fa_carry(xo[i], yo[i], carries[i]);
  end
endmodule

// File: rtl/slice_logic.sv
module slice_logic
  import alu_slice_pkg::*;
#(
  parameter int W = SLICE_W
) (
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  input  lg_e          op,
  output logic [W-1:0] out
);
  always_comb begin
    unique case (op)
      LG_OR:   out = x_in | y_in;
      LG_AND:  out = x_in & y_in;
      default: out = x_in ^ y_in;
    endcase
  end
endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_slice_pkg::*;
(
  input  logic [SLICE_W-1:0] a,
  input  logic [SLICE_W-1:0] b,
  input  logic               cin,
  input  logic [2:0]         fn_code,
  output logic [SLICE_W-1:0] f,
  output logic               cout,
  output logic               ovr
);
  slice_ctl_t         ctl;
  logic [SLICE_W-1:0] arith_f, logic_f;
  logic [SLICE_W:0]   cy;
  logic               msb_carry_in, msb_carry_out;

  slice_decode u_dec (.fn_code(fn_code), .ctl(ctl));

  slice_adder #(.W(SLICE_W)) u_add (
    .x_in(a), .y_in(b), .inv_x(ctl.inv_a), .inv_y(ctl.inv_b),
    .cin(cin), .sum(arith_f), .carries(cy)
  );

  slice_logic #(.W(SLICE_W)) u_lg (
    .x_in(a), .y_in(b), .op(ctl.lop), .out(logic_f)
  );

  assign msb_carry_in  = cy[SLICE_W-1];
  assign msb_carry_out = cy[SLICE_W];

  always_comb begin
    if (ctl.force_lo) begin
      f = '0; cout = 1'b1; ovr = 1'b1;
    end else if (ctl.force_hi) begin
      f = '1; cout = 1'b0; ovr = 1'b0;
    end else if (ctl.arith) begin
      f = arith_f; cout = msb_carry_out; ovr = msb_carry_in ^ msb_carry_out;
    end else begin
      f = logic_f; cout = 1'b0; ovr = 1'b0;
    end
  end
endmodule

// File: rtl/alu_chain.sv
module alu_chain
  import alu_slice_pkg::*;
#(
  parameter int NSLICES = 4,
  localparam int W = NSLICES * SLICE_W
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         carry_in,
  input  logic [2:0]   func_sel,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         overflow
);
  logic [NSLICES:0]   ripple;
  logic [NSLICES-1:0] slice_ovr;

  assign ripple[0] = carry_in;

  for (genvar s = 0; s < NSLICES; s++) begin : g_slice
    alu_slice u_slice (
      .a      (a_in[s*SLICE_W +: SLICE_W]),
      .b      (b_in[s*SLICE_W +: SLICE_W]),
      .cin    (ripple[s]),
      .fn_code(func_sel),
      .f      (result[s*SLICE_W +: SLICE_W]),
      .cout   (ripple[s+1]),
      .ovr    (slice_ovr[s])
    );
  end

  assign carry_out = ripple[NSLICES];
  assign overflow  = slice_ovr[NSLICES-1];
endmodule

// File: rtl/alu_chain_checker.sv
module alu_chain_checker #(
  parameter int NSLICES = 4,
  localparam int W = NSLICES * 4
) (
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic         carry_in,
  input logic [2:0]   func_sel,
  input logic [W-1:0] result,
  input logic         carry_out,
  input logic         overflow
);
  logic [W:0] add_ref, asubb_ref;
  logic       known;

  always_comb begin
    add_ref   = {1'b0, a_in} + {1'b0, b_in} + {{W{1'b0}}, carry_in};
    asubb_ref = {1'b0, a_in} + {1'b0, ~b_in} + {{W{1'b0}}, carry_in};
    known     = !$isunknown({a_in, b_in, carry_in, func_sel});
    if (known) begin
      if (func_sel == 3'b000)
        assert_clear_R1: assert (result == '0 && carry_out && overflow);
      if (func_sel == 3'b111)
        assert_preset_R2: assert (result == '1 && !carry_out && !overflow);
      if (func_sel == 3'b011)
        assert_add_R3: assert ({carry_out, result} == add_ref);
      if (func_sel == 3'b010)
        assert_asubb_R4: assert ({carry_out, result} == asubb_ref);
      if (func_sel == 3'b101)
        assert_or_R6: assert (result == (a_in | b_in) && !carry_out && !overflow);
      if (func_sel == 3'b011)
        assert_signed_ovf_R7: assert (overflow ==
          ((a_in[W-1] == b_in[W-1]) && (result[W-1] != a_in[W-1])));
    end
  end
endmodule

bind alu_chain alu_chain_checker #(.NSLICES(NSLICES)) u_chk (
  .a_in(a_in), .b_in(b_in), .carry_in(carry_in), .func_sel(func_sel),
  .result(result), .carry_out(carry_out), .overflow(overflow)
);

// File: tb/test_alu_chain.sv
module test_alu_chain;
  logic clk = 1'b0;
  always #10 clk = ~clk;
  logic rst = 1'b1;

  int n_checks = 0;
  int n_errors = 0;

  logic [15:0] a16 = '0, b16 = '0, r16;
  logic        c16 = 1'b0, co16, ov16;
  logic [2:0]  s16 = '0;
  logic [3:0]  a4 = '0, b4 = '0, r4;
  logic        c4 = 1'b0, co4, ov4;
  logic [2:0]  s4 = '0;

  alu_chain i_alu_chain (
    .a_in(a16), .b_in(b16), .carry_in(c16), .func_sel(s16),
    .result(r16), .carry_out(co16), .overflow(ov16)
  );

  alu_chain #(.NSLICES(1)) i_alu_chain_one (
    .a_in(a4), .b_in(b4), .carry_in(c4), .func_sel(s4),
    .result(r4), .carry_out(co4), .overflow(ov4)
  );

  function automatic string tag_of(int sel);
    case (sel)
      0: return "R1";
      1: return "R5";
      2: return "R4";
      3: return "R3";
      7: return "R2";
      default: return "R6";
    endcase
  endfunction

  // Expected values from the function table, computed with integers.
  function automatic void model(input int w, input longint a, input longint b,
                                input int cin, input int sel,
                                output longint f, output int c, output int o);
    longint mask = (longint'(1) << w) - 1;
    longint hm   = mask >> 1;
    longint x, y, s, lo;
    f = 0; c = 0; o = 0;
    case (sel)
      0: begin f = 0; c = 1; o = 1; end
      7: f = mask;
      4: f = (a ^ b) & mask;
      5: f = (a | b) & mask;
      6: f = (a & b) & mask;
      default: begin
        x = (sel == 1) ? b : a;
        y = (sel == 1) ? (~a & mask) : (sel == 2) ? (~b & mask) : b;
        s  = x + y + cin;
        f  = s & mask;
        c  = int'((s >> w) & 1);
        lo = ((x & hm) + (y & hm) + cin) >> (w - 1);
        o  = int'(lo & 1) ^ c;
      end
    endcase
  endfunction

  task automatic check(input string tag, input int w, input longint a,
                       input longint b, input int cin, input int sel,
                       input longint gf, input int gc, input int go);
    longint ef; int ec, eo;
    string t;
    model(w, a, b, cin, sel, ef, ec, eo);
    t = (tag == "") ? tag_of(sel) : tag;
    if (sel >= 1 && sel <= 3) t = {t, "/R7"};
    n_checks++;
    if (gf != ef || gc != ec || go != eo) begin
      n_errors++;
      $display("FAIL %s w=%0d sel=%0d a=%0h b=%0h cin=%0d: got f=%0h c=%0d o=%0d expected f=%0h c=%0d o=%0d",
               t, w, sel, a, b, cin, gf, gc, go, ef, ec, eo);
    end
  endtask

  task automatic run16(input string tag, input logic [15:0] a, input logic [15:0] b,
                       input logic cin, input logic [2:0] sel);
    @(posedge clk);
    a16 = a; b16 = b; c16 = cin; s16 = sel;
    @(negedge clk);
    check(tag, 16, a, b, cin, sel, r16, co16, ov16);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 at reset time: inputs idle at code 000
    check("R1", 16, 0, 0, 0, 0, r16, co16, ov16);
    check("R1", 4, 0, 0, 0, 0, r4, co4, ov4);
    rst = 1'b0;

    // R9 single slice, exhaustive over all codes, carries and operands
    for (int sel = 0; sel < 8; sel++)
      for (int cin = 0; cin < 2; cin++)
        for (int a = 0; a < 16; a++)
          for (int b = 0; b < 16; b++) begin
            @(posedge clk);
            a4 = 4'(a); b4 = 4'(b); c4 = 1'(cin); s4 = 3'(sel);
            @(negedge clk);
            check("", 4, a, b, cin, sel, r4, co4, ov4);
          end

    // R8 ripple across slices, R7 word overflow from the top slice
    run16("R8", 16'h0FFF, 16'h0001, 1'b0, 3'b011);
    run16("R8", 16'hFFFF, 16'h0000, 1'b1, 3'b011);
    run16("R7", 16'h7FFF, 16'h0001, 1'b0, 3'b011);
    run16("R7", 16'h8000, 16'h0001, 1'b1, 3'b010);
    run16("R4", 16'd100, 16'd30, 1'b1, 3'b010);
    run16("R5", 16'd100, 16'd30, 1'b1, 3'b001);
    run16("R1", 16'h1234, 16'h5678, 1'b0, 3'b000);
    run16("R2", 16'h1234, 16'h5678, 1'b1, 3'b111);
    run16("R9", 16'hA5A5, 16'h0FF0, 1'b1, 3'b110);

    // R8 random 16-bit vectors across all codes
    for (int k = 0; k < 3000; k++)
      run16("", 16'($urandom), 16'($urandom), 1'($urandom), 3'($urandom));

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule